// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block arbitrates among up to seven pending interrupt requests: one non-maskable request with a fixed level of 16, and a set of external request lines that each carry a programmable 4-bit priority. It picks the single highest-priority eligible request. It weighs that request against the processor's current 4-bit mask level and a block-interrupts control bit. It then issues a registered accept strobe together with the winning source code and level.

A priority of 0 turns a line off. The block-interrupts bit holds back every request, including the non-maskable one. The one exception is a low-power mode, where the non-maskable request still gets through and also raises a wake-up output. The block only reads the mask level and never drives it, so accepting a request cannot change it.

Top module: `irq_prio_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_stb`, `acc_src`, `acc_lvl` and `wake` are all 0 after that edge.
- R2: An external line whose priority field is 0 never wins, even when its request bit is set.
- R3: An external line is eligible only when its request bit is 1, `blk` is 0, and its priority is strictly greater than `mask_lvl`.
- R4: An eligible non-maskable request beats every external line and reports source code 0 with level 16.
- R5: The non-maskable request is eligible when `blk` is 0, or when `lp_mode` is 1 whatever the value of `blk`.
- R6: Among eligible external lines the highest priority wins. Equal priorities go to the lower line number. Line i reports source code i+1 and its own priority as the level.
- R7: `acc_stb` goes high for one cycle, one clock edge after the inputs present an eligible winner. While the same winner is held it does not go high again. It goes high again when the winning source code changes, or after a cycle with no winner.
- R8: `wake` is 1 one edge after `req_nmi` and `lp_mode` are both 1, regardless of `blk`, and is 0 otherwise.
- R9: `acc_src` and `acc_lvl` show the current winner one edge after the inputs, and are 0 when no request is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_nmi | input | 1 | Non-maskable request pending |
| req_ext | input | 6 | External request pending bits, bit i is line i |
| ext_prio | input | 24 | Priorities, line i in bits [4i+3:4i] |
| mask_lvl | input | 4 | Current processor mask level |
| blk | input | 1 | Block-interrupts control bit |
| lp_mode | input | 1 | Sleep or standby mode flag |
| acc_stb | output | 1 | Accept strobe |
| acc_src | output | 3 | Winning source code (0 = non-maskable, i+1 = line i) |
| acc_lvl | output | 5 | Winning level, 0 to 16 |
| wake | output | 1 | Wake-up request |

## Verification
Every output sits behind exactly one register. A stimulus driven on a falling edge is therefore due after the next rising edge, and the bench reads it on the falling edge that follows. Sweep vectors are separated by an idle cycle with all requests low, so each vector starts from a cleared winner history and its strobe is due in that first cycle. Held-input and winner-change sequences then check the second and third cycles, where the strobe must stay low or fire again.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int NMI_LEVEL = 16;
  localparam int NMI_CODE  = 0;
endpackage

// File: rtl/irq_line_qual.sv
module irq_line_qual #(
  parameter int PW = 4
) (
  input  logic          req,
  input  logic [PW-1:0] prio,
  input  logic [PW-1:0] mask_lvl,
  input  logic          blk,
  output logic [PW-1:0] lvl_o
);
  always_comb begin
    if (req && !blk && (prio > mask_lvl)) lvl_o = prio;
    else                                  lvl_o = '0;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_res_pkg::*;
#(
  parameter int N_EXT = 6,
  parameter int PW    = 4,
  localparam int SW   = $clog2(N_EXT + 1),
  localparam int LW   = PW + 1
) (
  input  logic [N_EXT*PW-1:0] lvls,
  input  logic                nmi_ok,
  output logic                win_vld,
  output logic [SW-1:0]       win_src,
  output logic [LW-1:0]       win_lvl
);
  always_comb begin
    win_vld = 1'b0;
    win_src = '0;
    win_lvl = '0;
    for (int i = 0; i < N_EXT; i++) begin
      if (LW'(lvls[i*PW +: PW]) > win_lvl) begin
        win_vld = 1'b1;
        win_src = SW'(i + 1);
        win_lvl = LW'(lvls[i*PW +: PW]);
      end
    end
    if (nmi_ok) begin
      win_vld = 1'b1;
      win_src = SW'(NMI_CODE);
      win_lvl = LW'(NMI_LEVEL);
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N_EXT = 6,
  parameter int PW    = 4,
  localparam int SW   = $clog2(N_EXT + 1),
  localparam int LW   = PW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_nmi,
  input  logic [N_EXT-1:0]    req_ext,
  input  logic [N_EXT*PW-1:0] ext_prio,
  input  logic [PW-1:0]       mask_lvl,
  input  logic                blk,
  input  logic                lp_mode,
  output logic                acc_stb,
  output logic [SW-1:0]       acc_src,
  output logic [LW-1:0]       acc_lvl,
  output logic                wake
);
  logic [N_EXT*PW-1:0] lvls;
  logic                nmi_ok;
  logic                win_vld;
  logic [SW-1:0]       win_src;
  logic [LW-1:0]       win_lvl;
  logic                last_vld;

  for (genvar g = 0; g < N_EXT; g++) begin : g_line
    irq_line_qual #(.PW(PW)) u_q (
      .req      (req_ext[g]),
      .prio     (ext_prio[g*PW +: PW]),
      .mask_lvl (mask_lvl),
      .blk      (blk),
      .lvl_o    (lvls[g*PW +: PW])
    );
  end

  assign nmi_ok = req_nmi && (!blk || lp_mode);

  irq_pick #(.N_EXT(N_EXT), .PW(PW)) u_pick (
    .lvls    (lvls),
    .nmi_ok  (nmi_ok),
    .win_vld (win_vld),
    .win_src (win_src),
    .win_lvl (win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_stb  <= 1'b0;
      acc_src  <= '0;
      acc_lvl  <= '0;
      wake     <= 1'b0;
      last_vld <= 1'b0;
    end else begin
      acc_stb  <= win_vld && (!last_vld || (win_src != acc_src));
      acc_src  <= win_src;
      acc_lvl  <= win_lvl;
      wake     <= req_nmi && lp_mode;
      last_vld <= win_vld;
    end
  end
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int N_EXT = 6,
  parameter int PW    = 4,
  localparam int SW   = $clog2(N_EXT + 1),
  localparam int LW   = PW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_nmi,
  input logic [PW-1:0] mask_lvl,
  input logic          blk,
  input logic          lp_mode,
  input logic          acc_stb,
  input logic [SW-1:0] acc_src,
  input logic [LW-1:0] acc_lvl,
  input logic          wake
);
  p_nonzero_lvl_r2: assert property (@(posedge clk) disable iff (rst)
    acc_stb |-> acc_lvl != '0);
  p_above_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && acc_src != '0) |-> (acc_lvl > LW'($past(mask_lvl))) && !$past(blk));
  p_nmi_level_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && acc_src == '0) |-> acc_lvl == LW'(16));
  p_nmi_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && acc_src == '0) |-> (!$past(blk) || $past(lp_mode)));
  p_no_repeat_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && $past(acc_stb)) |-> acc_src != $past(acc_src));
  p_wake_cause_r8: assert property (@(posedge clk) disable iff (rst)
    wake |-> ($past(req_nmi) && $past(lp_mode)));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.N_EXT(N_EXT), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .req_nmi(req_nmi), .mask_lvl(mask_lvl), .blk(blk),
  .lp_mode(lp_mode), .acc_stb(acc_stb), .acc_src(acc_src), .acc_lvl(acc_lvl),
  .wake(wake)
);

// File: tb/sim_irq_prio_resolver.sv
`timescale 1ns/1ps
module sim_irq_prio_resolver;
  localparam int N = 6;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_nmi = 1'b0;
  logic [N-1:0]  req_ext = '0;
  logic [N*PW-1:0] ext_prio = '0;
  logic [PW-1:0] mask_lvl = '0;
  logic          blk = 1'b0;
  logic          lp_mode = 1'b0;
  logic          acc_stb;
  logic [2:0]    acc_src;
  logic [4:0]    acc_lvl;
  logic          wake;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_resolver u0 (
    .clk(clk), .rst(rst), .req_nmi(req_nmi), .req_ext(req_ext),
    .ext_prio(ext_prio), .mask_lvl(mask_lvl), .blk(blk), .lp_mode(lp_mode),
    .acc_stb(acc_stb), .acc_src(acc_src), .acc_lvl(acc_lvl), .wake(wake)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // expected winner from the requirements: returns valid, fills src/lvl
  function automatic bit model(output int src, output int lvl);
    bit v = 1'b0;
    src = 0; lvl = 0;
    for (int i = 0; i < N; i++) begin
      int p = int'(ext_prio[i*PW +: PW]);
      if (req_ext[i] && !blk && p != 0 && p > int'(mask_lvl) && p > lvl) begin
        v = 1'b1; src = i + 1; lvl = p;
      end
    end
    if (req_nmi && (!blk || lp_mode)) begin
      v = 1'b1; src = 0; lvl = 16;
    end
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    req_nmi = 1'b0; req_ext = '0;
  endtask

  initial begin
    int es, el;
    bit ev;
    @(negedge clk);
    step();
    // R1 reset state
    check("R1 stb", acc_stb, 0);
    check("R1 src", acc_src, 0);
    check("R1 lvl", acc_lvl, 0);
    check("R1 wake", wake, 0);
    rst = 1'b0;
    step();

    // sweep: R2 R3 R4 R5 R6 R8 R9 with R7 first-cycle strobe
    for (int k = 0; k < 512; k++) begin
      for (int i = 0; i < N; i++) ext_prio[i*PW +: PW] = PW'((k*(i+3) + i*5) % 16);
      req_ext  = N'((k*37) % 64);
      mask_lvl = PW'(k % 16);
      blk      = ((k/16) % 2) == 1;
      lp_mode  = ((k/32) % 2) == 1;
      req_nmi  = ((k/64) % 2) == 1;
      ev = model(es, el);
      step();
      check("R7 stb first", acc_stb, int'(ev));
      check("R6 src", acc_src, es);
      check("R6 lvl", acc_lvl, el);
      check("R8 wake", wake, int'(req_nmi && lp_mode));
      idle();
      step();
      check("R9 idle src", acc_src, 0);
      check("R9 idle lvl", acc_lvl, 0);
      check("R7 idle stb", acc_stb, 0);
    end

    // R2: priority 0 line with request, nothing else
    blk = 0; lp_mode = 0; mask_lvl = 0; ext_prio = '0;
    req_ext = 6'b000001;
    step();
    check("R2 stb", acc_stb, 0);
    check("R2 src", acc_src, 0);
    idle(); step();

    // R6 tie: lines 2 and 4 both priority 7 -> code 3
    ext_prio = '0; ext_prio[2*PW +: PW] = 4'd7; ext_prio[4*PW +: PW] = 4'd7;
    req_ext = 6'b010100;
    step();
    check("R6 tie src", acc_src, 3);
    check("R6 tie lvl", acc_lvl, 7);
    // R7 held: no second strobe
    step();
    check("R7 held stb", acc_stb, 0);
    check("R7 held src", acc_src, 3);
    // R7 winner change: line 5 priority 9 -> new strobe
    ext_prio[5*PW +: PW] = 4'd9; req_ext = 6'b110100;
    step();
    check("R7 change stb", acc_stb, 1);
    check("R7 change src", acc_src, 6);
    // R4 NMI over line 5
    req_nmi = 1'b1;
    step();
    check("R4 stb", acc_stb, 1);
    check("R4 src", acc_src, 0);
    check("R4 lvl", acc_lvl, 16);
    // R3 mask equal to priority: line 5 (9) masked at 9, line 2/4 too
    idle(); step();
    mask_lvl = 4'd9; req_ext = 6'b100000;
    step();
    check("R3 equal mask stb", acc_stb, 0);
    mask_lvl = 4'd8;
    step();
    check("R3 above mask stb", acc_stb, 1);
    // R5: blk with lp_mode lets NMI through and raises wake
    idle(); step();
    blk = 1'b1; lp_mode = 1'b1; req_nmi = 1'b1; req_ext = 6'b100000;
    step();
    check("R5 lp stb", acc_stb, 1);
    check("R5 lp src", acc_src, 0);
    check("R8 lp wake", wake, 1);
    lp_mode = 1'b0;
    step();
    check("R5 blocked src", acc_src, 0);
    check("R5 blocked lvl", acc_lvl, 0);
    check("R8 no lp wake", wake, 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule